// File: doc/BRIEF.md
# Serial ROM Image Loader with Integrity Checks

This block fetches a configuration image from a bit-serial EEPROM and decides whether it can be trusted. A start pulse carries a base offset and a presence flag. After the base offset is range-checked, the loader opens a first read transaction for the two-byte length field. It works out the total image size and, if that size lies within bounds, opens a second transaction that streams the whole image past two checksum engines.

The first engine is an 8-bit CRC over the 64-bit identifier. The second is an inverted, reflected CRC-32C over the payload. Once the image has been read, the block raises `done` and holds a pass flag, a reason code, the identifier, the payload length and a revision warning until the next start. The serial clock is the system clock divided by `2*CLK_DIV`.

Top module: `romimg_loader`

## Requirements
- R1: Each read transaction drives `rom_cs_n` low, sends command 0x03, then the upper address byte, then the lower address byte, and then clocks in data bytes. `rom_cs_n` returns high when the last byte has been received. The length read addresses base+14 and the image read addresses base. `rom_cs_n` is low only while `busy` is high.
- R2: Bytes travel most significant bit first, with eight clock pulses per byte. `rom_sdo` changes only while `rom_sck` is low, `rom_sdi` is sampled as `rom_sck` rises, and `rom_sck` stays low whenever `rom_cs_n` is high.
- R3: The payload length is the little-endian 16-bit value at image offsets 14 (low byte) and 15 (high byte), and it is reported on `pay_len`. The total image size is length+13.
- R4: A total size below 17 bytes ends the load with code 3. No second transaction takes place.
- R5: A total size above `MAX_IMG` ends the load with code 4. No second transaction takes place. A size equal to `MAX_IMG` is accepted.
- R6: The CRC-8 (polynomial 0x07, shifting left, starting from `CRC8_INIT`, default 0xFF) is computed over image bytes 1..8 and compared with byte 0. A mismatch gives code 5. `img_uid` holds bytes 1..8 with byte 1 as the least significant byte.
- R7: The CRC-32C (reflected, polynomial 0x82F63B78, initial value all ones, result inverted) is computed over bytes 13..size-1 and compared with the little-endian word in bytes 9..12. A mismatch gives code 6. When both checks fail, code 5 is reported.
- R8: A revision byte (offset 16) greater than 1 sets `rev_warn` but does not fail the load.
- R9: If `rom_absent` is high at start, the load ends with code 1. If `base_off[31:16]` is nonzero, it ends with code 2. In both cases no transaction takes place.
- R10: `busy` is high from start until the result is ready. `done`, `pass` and `err_code` then hold until the next accepted start. A start pulse while `busy` is high is ignored. `pass` is set only when `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (accepted when not busy) |
| base_off | input | 32 | Image base offset in the EEPROM |
| rom_absent | input | 1 | EEPROM not fitted |
| rom_cs_n | output | 1 | EEPROM chip select, active low |
| rom_sck | output | 1 | EEPROM serial clock |
| rom_sdo | output | 1 | Serial data to EEPROM |
| rom_sdi | input | 1 | Serial data from EEPROM |
| busy | output | 1 | Load in progress |
| done | output | 1 | Result valid |
| pass | output | 1 | Image accepted |
| err_code | output | 3 | Reason: 0 ok, 1 absent, 2 offset range, 3 too small, 4 too large, 5 id CRC, 6 payload CRC |
| rev_warn | output | 1 | Revision byte above 1 |
| img_uid | output | 64 | Identifier, little endian |
| pay_len | output | 16 | Payload length field |

## Verification
The hardest cases to reach from the ports are the size boundaries and the ordering between the two integrity checks. Each of these needs an EEPROM image that is consistent in every respect except the one being tested. The bench models the EEPROM as a serial slave that decodes the command and address MSB first and records every transaction. Each image is built with its own checksums and then corrupted in a controlled way: the identifier CRC alone, the payload CRC alone, or both together. The length field is set to 3, 4, 51 and 52, which lands on each side of both size limits. A second start pulse is also sent in the middle of a load.

// File: rtl/romimg_pkg.sv
package romimg_pkg;

  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_ABSENT = 3'd1,
    ERR_RANGE  = 3'd2,
    ERR_SMALL  = 3'd3,
    ERR_OVER   = 3'd4,
    ERR_UID    = 3'd5,
    ERR_DATA   = 3'd6
  } err_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_CMD, ST_RX, ST_SIZE, ST_EVAL, ST_DONE
  } st_e;

  localparam logic [7:0]  CMD_READ   = 8'h03;
  localparam int          HDR_BYTES  = 17;
  localparam int          PAY_START  = 13;
  localparam logic [15:0] LEN_OFF    = 16'd14;
  localparam int          REV_OFF    = 16;
  localparam int          C32_OFF    = 9;
  localparam logic [31:0] C32_POLY   = 32'h82F63B78;

  function automatic logic [7:0] crc8_next(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] v;
    v = c ^ d;
    for (int b = 0; b < 8; b++)
      v = v[7] ? ((v << 1) ^ 8'h07) : (v << 1);
    return v;
  endfunction

  function automatic logic [31:0] crc32c_next(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] v;
    v = c ^ {24'd0, d};
    for (int b = 0; b < 8; b++)
      v = v[0] ? ((v >> 1) ^ C32_POLY) : (v >> 1);
    return v;
  endfunction

endpackage

// File: rtl/romimg_bitshift.sv
module romimg_bitshift #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx,
  output logic       sck,
  output logic       sdo,
  input  logic       sdi
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic          busy_q, busy_d, done_q, done_d, sck_q, sck_d;
  logic [7:0]    sh_q, sh_d, rx_q, rx_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    bit_q, bit_d;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    sck_d  = sck_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    if (!busy_q) begin
      if (go) begin
        busy_d = 1'b1;
        sh_d   = tx;
        cnt_d  = '0;
        bit_d  = '0;
        sck_d  = 1'b0;
      end
    end else if (cnt_q == CW'(DIV - 1)) begin
      cnt_d = '0;
      if (!sck_q) begin
        sck_d = 1'b1;
        rx_d  = {rx_q[6:0], sdi};
      end else begin
        sck_d = 1'b0;
        if (bit_q == 3'd7) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + 3'd1;
          sh_d  = {sh_q[6:0], 1'b0};
        end
      end
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sck_q  <= 1'b0;
      sh_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
      bit_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      sck_q  <= sck_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign rx   = rx_q;
  assign sck  = sck_q;
  assign sdo  = busy_q & sh_q[7];
endmodule

// File: rtl/romimg_crc8_acc.sv
module romimg_crc8_acc #(
  parameter logic [7:0] INIT = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  import romimg_pkg::*;
  logic [7:0] c_q, c_d;

  always_comb begin
    c_d = c_q;
    if (clr)     c_d = INIT;
    else if (en) c_d = crc8_next(c_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) c_q <= INIT;
    else        c_q <= c_d;
  end

  assign crc = c_q;
endmodule

// File: rtl/romimg_crc32c_acc.sv
module romimg_crc32c_acc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc
);
  import romimg_pkg::*;
  logic [31:0] c_q, c_d;

  always_comb begin
    c_d = c_q;
    if (clr)     c_d = '1;
    else if (en) c_d = crc32c_next(c_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) c_q <= '1;
    else        c_q <= c_d;
  end

  assign crc = ~c_q;
endmodule

// File: rtl/romimg_loader.sv
module romimg_loader #(
  parameter int         CLK_DIV   = 4,
  parameter int         MAX_IMG   = 64,
  parameter logic [7:0] CRC8_INIT = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] base_off,
  input  logic        rom_absent,
  output logic        rom_cs_n,
  output logic        rom_sck,
  output logic        rom_sdo,
  input  logic        rom_sdi,
  output logic        busy,
  output logic        done,
  output logic        pass,
  output logic [2:0]  err_code,
  output logic        rev_warn,
  output logic [63:0] img_uid,
  output logic [15:0] pay_len
);
  import romimg_pkg::*;

  localparam int IW = $clog2(MAX_IMG + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  st_e            st_q, st_d;
  logic           img_q, img_d, absent_q, absent_d, range_q, range_d;
  logic           done_q, done_d, pass_q, pass_d, warn_q, warn_d;
  logic [1:0]     cmd_q, cmd_d;
  logic [IW-1:0]  idx_q, idx_d, size_q, size_d;
  logic [15:0]    base_q, base_d, len_q, len_d, addr;
  logic [63:0]    uid_q, uid_d;
  logic [7:0]     exp8_q, exp8_d, rev_q, rev_d, tx_byte, rx_byte;
  logic [31:0]    exp32_q, exp32_d, crc32;
  logic [7:0]     crc8;
  err_e           err_q, err_d;
  logic [16:0]    size17;
  logic           eng_go, eng_busy, eng_done, crc_clr, crc8_en, crc32_en, last;

  assign addr   = img_q ? base_q : base_q + LEN_OFF;
  assign size17 = {1'b0, len_q} + 17'(PAY_START);
  assign last   = img_q ? (idx_q == size_q - IW'(1)) : (idx_q == IW'(1));

  always_comb begin
    unique case (cmd_q)
      2'd0:    tx_byte = CMD_READ;
      2'd1:    tx_byte = addr[15:8];
      default: tx_byte = addr[7:0];
    endcase
    if (st_q != ST_CMD) tx_byte = 8'h00;
  end

  always_comb begin
    st_d = st_q;  img_d = img_q;  absent_d = absent_q;  range_d = range_q;
    done_d = done_q;  pass_d = pass_q;  warn_d = warn_q;  cmd_d = cmd_q;
    idx_d = idx_q;  size_d = size_q;  base_d = base_q;  len_d = len_q;
    uid_d = uid_q;  exp8_d = exp8_q;  exp32_d = exp32_q;  rev_d = rev_q;
    err_d = err_q;
    crc_clr = 1'b0;  crc8_en = 1'b0;  crc32_en = 1'b0;  eng_go = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          st_d = ST_CHECK;  done_d = 1'b0;  pass_d = 1'b0;  warn_d = 1'b0;
          err_d = ERR_NONE;  uid_d = '0;  len_d = '0;  rev_d = '0;
          absent_d = rom_absent;  range_d = |base_off[31:16];
          base_d = base_off[15:0];  crc_clr = 1'b1;
        end
      end
      ST_CHECK: begin
        if (absent_q) begin
          err_d = ERR_ABSENT;  st_d = ST_DONE;  done_d = 1'b1;
        end else if (range_q) begin
          err_d = ERR_RANGE;  st_d = ST_DONE;  done_d = 1'b1;
        end else begin
          st_d = ST_CMD;  img_d = 1'b0;  cmd_d = '0;  idx_d = '0;
        end
      end
      ST_CMD: begin
        eng_go = !eng_busy && !eng_done;
        if (eng_done) begin
          if (cmd_q == 2'd2) begin
            st_d = ST_RX;  idx_d = '0;
          end else begin
            cmd_d = cmd_q + 2'd1;
          end
        end
      end
      ST_RX: begin
        eng_go = !eng_busy && !eng_done;
        if (eng_done) begin
          idx_d = idx_q + IW'(1);
          if (!img_q) begin
            if (idx_q == '0) len_d[7:0]  = rx_byte;
            else             len_d[15:8] = rx_byte;
          end else begin
            if (idx_q == '0) exp8_d = rx_byte;
            for (int k = 0; k < 8; k++)
              if (idx_q == IW'(k + 1)) uid_d[8*k +: 8] = rx_byte;
            for (int k = 0; k < 4; k++)
              if (idx_q == IW'(C32_OFF + k)) exp32_d[8*k +: 8] = rx_byte;
            if (idx_q == IW'(REV_OFF)) rev_d = rx_byte;
            crc8_en  = (idx_q >= IW'(1)) && (idx_q <= IW'(8));
            crc32_en = (idx_q >= IW'(PAY_START));
          end
          if (last) st_d = img_q ? ST_EVAL : ST_SIZE;
        end
      end
      ST_SIZE: begin
        if (size17 < 17'(HDR_BYTES)) begin
          err_d = ERR_SMALL;  st_d = ST_DONE;  done_d = 1'b1;
        end else if (size17 > 17'(MAX_IMG)) begin
          err_d = ERR_OVER;  st_d = ST_DONE;  done_d = 1'b1;
        end else begin
          size_d = size17[IW-1:0];  st_d = ST_CMD;  img_d = 1'b1;
          cmd_d = '0;  idx_d = '0;
        end
      end
      ST_EVAL: begin
        st_d = ST_DONE;  done_d = 1'b1;  warn_d = (rev_q > 8'd1);
        if (crc8 != exp8_q)        err_d = ERR_UID;
        else if (crc32 != exp32_q) err_d = ERR_DATA;
        else                       pass_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q <= ST_IDLE;  img_q <= 1'b0;  absent_q <= 1'b0;  range_q <= 1'b0;
      done_q <= 1'b0;  pass_q <= 1'b0;  warn_q <= 1'b0;  cmd_q <= '0;
      idx_q <= '0;  size_q <= '0;  base_q <= '0;  len_q <= '0;
      uid_q <= '0;  exp8_q <= '0;  exp32_q <= '0;  rev_q <= '0;
      err_q <= ERR_NONE;
    end else begin
      st_q <= st_d;  img_q <= img_d;  absent_q <= absent_d;  range_q <= range_d;
      done_q <= done_d;  pass_q <= pass_d;  warn_q <= warn_d;  cmd_q <= cmd_d;
      idx_q <= idx_d;  size_q <= size_d;  base_q <= base_d;  len_q <= len_d;
      uid_q <= uid_d;  exp8_q <= exp8_d;  exp32_q <= exp32_d;  rev_q <= rev_d;
      err_q <= err_d;
    end
  end

  romimg_bitshift #(.DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(srst_n), .go(eng_go), .tx(tx_byte), .busy(eng_busy),
    .done(eng_done), .rx(rx_byte), .sck(rom_sck), .sdo(rom_sdo), .sdi(rom_sdi)
  );

  romimg_crc8_acc #(.INIT(CRC8_INIT)) u_crc8 (
    .clk(clk), .rst_n(srst_n), .clr(crc_clr), .en(crc8_en), .din(rx_byte), .crc(crc8)
  );

  romimg_crc32c_acc u_crc32 (
    .clk(clk), .rst_n(srst_n), .clr(crc_clr), .en(crc32_en), .din(rx_byte), .crc(crc32)
  );

  assign rom_cs_n = !((st_q == ST_CMD) || (st_q == ST_RX));
  assign busy     = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign done     = done_q;
  assign pass     = pass_q;
  assign err_code = err_q;
  assign rev_warn = warn_q;
  assign img_uid  = uid_q;
  assign pay_len  = len_q;
endmodule

// File: rtl/romimg_loader_chk.sv
module romimg_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sck,
  input logic       sdo,
  input logic       busy,
  input logic       done,
  input logic       pass,
  input logic [2:0] err_code
);
  // R2
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);
  // R2
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(sdo));
  // R1
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> busy);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R10
  pass_code_chk: assert property (@(posedge clk) disable iff (!rst_n) pass |-> (err_code == 3'd0));
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> ($stable(pass) && $stable(err_code)));
endmodule

bind romimg_loader romimg_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(rom_cs_n), .sck(rom_sck), .sdo(rom_sdo),
  .busy(busy), .done(done), .pass(pass), .err_code(err_code)
);

// File: tb/romimg_loader_tb.sv
module romimg_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_off = '0;
  logic        rom_absent = 1'b0;
  logic        rom_cs_n, rom_sck, rom_sdo;
  logic        rom_sdi = 1'b0;
  logic        busy, done, pass, rev_warn;
  logic [2:0]  err_code;
  logic [63:0] img_uid;
  logic [15:0] pay_len;

  always #5 clk = ~clk;

  romimg_loader #(.CLK_DIV(2), .MAX_IMG(64), .CRC8_INIT(8'hFF)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_off(base_off),
    .rom_absent(rom_absent), .rom_cs_n(rom_cs_n), .rom_sck(rom_sck),
    .rom_sdo(rom_sdo), .rom_sdi(rom_sdi), .busy(busy), .done(done),
    .pass(pass), .err_code(err_code), .rev_warn(rev_warn),
    .img_uid(img_uid), .pay_len(pay_len)
  );

  int applied = 0;
  int failed  = 0;
  int results = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    applied++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- EEPROM model (MSB first, mode 0) ----------------
  logic [7:0]  rom [0:255];
  int          bcnt = 0;
  logic [23:0] hdr = '0;
  int          txn_n = 0;
  logic [7:0]  txn_cmd  [0:3];
  logic [15:0] txn_addr [0:3];

  always @(negedge rom_cs_n) begin
    bcnt = 0;
    hdr  = '0;
  end
  always @(posedge rom_sck) if (!rom_cs_n) begin
    if (bcnt < 24) hdr = {hdr[22:0], rom_sdo};
    bcnt++;
  end
  always @(negedge rom_sck) if (!rom_cs_n && bcnt >= 24) begin
    int o;
    o = bcnt - 24;
    rom_sdi <= rom[(int'(hdr[15:0]) + o / 8) % 256][7 - (o % 8)];
  end
  always @(posedge rom_cs_n) if (bcnt > 0) begin
    if (txn_n < 4) begin
      txn_cmd[txn_n]  = hdr[23:16];
      txn_addr[txn_n] = hdr[15:0];
    end
    txn_n++;
    bcnt = 0;
  end

  // ---------------- image builder ----------------
  function automatic logic [7:0] ref_crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] v;
    v = c ^ d;
    for (int b = 0; b < 8; b++) v = v[7] ? ((v << 1) ^ 8'h07) : (v << 1);
    return v;
  endfunction

  function automatic logic [31:0] ref_crc32(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] v;
    v = c ^ {24'd0, d};
    for (int b = 0; b < 8; b++) v = v[0] ? ((v >> 1) ^ 32'h82F63B78) : (v >> 1);
    return v;
  endfunction

  task automatic build(input int base, input int len, input logic [7:0] rev,
                       input bit bad_uid, input bit bad_dat, output logic [63:0] uid);
    int size;
    logic [7:0]  c8;
    logic [31:0] c32;
    size = len + 13;
    if (size < 17) size = 17;
    for (int k = 0; k < size; k++) rom[(base + k) % 256] = 8'((k * 37 + base * 11 + len) & 255);
    rom[(base + 14) % 256] = 8'(len & 255);
    rom[(base + 15) % 256] = 8'(len >> 8);
    rom[(base + 16) % 256] = rev;
    c8 = 8'hFF;
    uid = '0;
    for (int k = 1; k <= 8; k++) begin
      c8 = ref_crc8(c8, rom[(base + k) % 256]);
      uid[8*(k-1) +: 8] = rom[(base + k) % 256];
    end
    c32 = '1;
    for (int k = 13; k < len + 13; k++) c32 = ref_crc32(c32, rom[(base + k) % 256]);
    c32 = ~c32;
    rom[base % 256] = bad_uid ? ~c8 : c8;
    if (bad_dat) c32 = c32 ^ 32'h0000_0100;
    for (int k = 0; k < 4; k++) rom[(base + 9 + k) % 256] = c32[8*k +: 8];
  endtask

  // ---------------- scoreboard ----------------
  typedef struct {
    logic        pass;
    logic [2:0]  err;
    logic        warn;
    logic [63:0] uid;
    logic [15:0] len;
  } exp_t;
  exp_t exp_q[$];
  logic done_seen = 1'b0;

  always @(negedge clk) begin
    if (done && !done_seen && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk("R10 pass flag", 64'(pass), 64'(e.pass));
      chk("R4/R5/R6/R7/R9 err_code", 64'(err_code), 64'(e.err));
      chk("R8 rev_warn", 64'(rev_warn), 64'(e.warn));
      chk("R10 busy low at done", 64'(busy), 64'd0);
      if (e.pass) begin
        chk("R6 img_uid", img_uid, e.uid);
        chk("R3 pay_len", 64'(pay_len), 64'(e.len));
      end
      results++;
    end
    done_seen <= done;
  end

  task automatic run(input logic [31:0] base, input bit absent, input exp_t e,
                     input int ntxn, input bit poke);
    int r0;
    r0 = results;
    txn_n = 0;
    exp_q.push_back(e);
    @(negedge clk);
    start = 1'b1;  base_off = base;  rom_absent = absent;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (300) @(negedge clk);
      start = 1'b1;  base_off = 32'h0000_0077;  rom_absent = 1'b1;   // R10: ignored
      @(negedge clk);
      start = 1'b0;  rom_absent = 1'b0;
    end
    while (results == r0) @(negedge clk);
    chk("R1 transaction count", 64'(txn_n), 64'(ntxn));
    if (ntxn >= 1) begin
      chk("R1/R2 command byte", 64'(txn_cmd[0]), 64'h03);
      chk("R1 length address", 64'(txn_addr[0]), 64'((base[15:0] + 16'd14)));
    end
    if (ntxn >= 2) begin
      chk("R1/R2 command byte", 64'(txn_cmd[1]), 64'h03);
      chk("R1 image address", 64'(txn_addr[1]), 64'(base[15:0]));
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic exp_t mk(input logic p, input logic [2:0] er, input logic w,
                              input logic [63:0] u, input int l);
    exp_t e;
    e.pass = p;  e.err = er;  e.warn = w;  e.uid = u;  e.len = 16'(l);
    return e;
  endfunction

  initial begin
    logic [63:0] u;
    for (int k = 0; k < 256; k++) rom[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 reset cs_n", 64'(rom_cs_n), 64'd1);
    chk("R2 reset sck", 64'(rom_sck), 64'd0);
    chk("R10 reset busy", 64'(busy), 64'd0);
    chk("R10 reset done", 64'(done), 64'd0);

    build(16, 20, 8'd0, 0, 0, u);   run(32'h10, 0, mk(1, 3'd0, 0, u, 20), 2, 0);   // R3 R6 R7
    build(64, 4, 8'd1, 0, 0, u);    run(32'h40, 0, mk(1, 3'd0, 0, u, 4), 2, 0);    // R4 boundary
    build(128, 51, 8'd2, 0, 0, u);  run(32'h80, 0, mk(1, 3'd0, 1, u, 51), 2, 0);   // R5 boundary, R8
    build(128, 52, 8'd0, 0, 0, u);  run(32'h80, 0, mk(0, 3'd4, 0, u, 52), 1, 0);   // R5
    build(32, 3, 8'd0, 0, 0, u);    run(32'h20, 0, mk(0, 3'd3, 0, u, 3), 1, 0);    // R4
    build(48, 10, 8'd0, 1, 0, u);   run(32'h30, 0, mk(0, 3'd5, 0, u, 10), 2, 0);   // R6
    build(48, 10, 8'd3, 0, 1, u);   run(32'h30, 0, mk(0, 3'd6, 1, u, 10), 2, 0);   // R7 R8
    build(48, 10, 8'd0, 1, 1, u);   run(32'h30, 0, mk(0, 3'd5, 0, u, 10), 2, 0);   // R7 priority
    run(32'h30, 1, mk(0, 3'd1, 0, u, 0), 0, 0);                                     // R9 absent
    run(32'h0001_0030, 0, mk(0, 3'd2, 0, u, 0), 0, 0);                              // R9 range
    build(160, 30, 8'd0, 0, 0, u);  run(32'hA0, 0, mk(1, 3'd0, 0, u, 30), 2, 1);   // R10 restart ignored

    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end
endmodule